// File: doc/BRIEF.md
# Sleep Timer and Watchdog

This block turns a slow reference tick of nominally 32.768 kHz into a periodic wake-up event. The tick arrives as a one-cycle enable on the system clock. A shared binary divider counts the ticks, and a two-bit rate field picks which power-of-two group of ticks forms one sleep period. Each completed period is a sleep event. When the interrupt is unmasked, an event produces a one-cycle interrupt request.

The same events drive a watchdog. Firmware arms it once with a strobe. The watchdog then counts sleep events, and the third event that is not preceded by a clear produces a one-cycle system reset pulse. Because the timeout is measured in sleep periods, a change of rate also changes the timeout. The arm state is sticky: clear strobes and the watchdog's own resets leave it set. Only power-on or external reset returns it to idle. After each watchdog reset the divider starts again from zero.

Top module: `sleep_watch_top`

## Requirements
- R1: With rate code 0, 1, 2 or 3 on `rate_sel_i`, a sleep event occurs on every 2^e-th tick since the divider last restarted. The exponent e is BASE_EXP + EXP_STEP × code, which gives 6, 9, 12 and 15 with the default parameters.
- R2: The divider advances only in cycles where `tick_i` is 1. Cycles without a tick change no count.
- R3: The rate field is applied to the running count. After a change, the next event falls on the first tick that arrives while the low e bits of the count are all ones for the new e.
- R4: `sleep_irq_o` is 1 for exactly the one cycle after a cycle that holds a sleep event and has `irq_en_i` = 1. With `irq_en_i` = 0, an event produces no pulse.
- R5: After power-on or external reset, the watchdog is not armed, and sleep events never produce `wd_reset_o`.
- R6: Once armed by `wd_arm_i`, the watchdog raises `wd_reset_o` for one cycle, the cycle after the third sleep event counted since it was armed, last cleared, or last fired.
- R7: A `wd_kick_i` strobe sets the event count to zero. A strobe in the same cycle as a sleep event leaves the count at zero and suppresses any reset in that cycle.
- R8: A watchdog reset leaves the watchdog armed, zeroes its count and restarts the divider from zero, so the next reset follows three further full periods.
- R9: Clear strobes cannot disarm the watchdog. Only `por_n_i` or `xrst_n_i` going low returns it to the unarmed state.
- R10: While either reset input is low, both outputs are 0 and the divider is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| xrst_n_i | input | 1 | External reset, active low, asynchronous |
| tick_i | input | 1 | One-cycle enable for each 32 kHz reference tick |
| rate_sel_i | input | 2 | Sleep rate code (0 fastest, 3 slowest) |
| wd_arm_i | input | 1 | Strobe that arms the watchdog (sticky) |
| wd_kick_i | input | 1 | Strobe that clears the watchdog event count |
| irq_en_i | input | 1 | 1 lets sleep events raise the interrupt |
| sleep_irq_o | output | 1 | One-cycle sleep interrupt request |
| wd_reset_o | output | 1 | One-cycle watchdog system reset pulse |

## Verification
Some properties are checked on every cycle by assertions. An interrupt pulse always follows an unmasked cycle. A reset pulse never lasts two cycles and never follows a clear. The event count stays below the limit. Once the watchdog is armed, it stays armed until a hard reset. Other behaviour can only be shown by the bench's scenarios against its reference model: the exact spacing of events for each rate, the effect of a rate change on a running count, sparse ticking, a clear coinciding with an event, and the divider restart after a watchdog reset.

// File: rtl/swd_pkg.sv
package swd_pkg;

    typedef logic [1:0] rate_code_t;

    typedef struct packed {
        logic irq;
        logic wdr;
    } swd_out_t;

    function automatic int unsigned rate_exp(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned code);
        return base + step * code;
    endfunction

endpackage

// File: rtl/swd_divider.sv
module swd_divider
    import swd_pkg::*;
#(
    parameter int unsigned BASE_EXP = 6,
    parameter int unsigned EXP_STEP = 3,
    parameter int unsigned CNT_W    = BASE_EXP + 3 * EXP_STEP
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       restart_i,
    input  rate_code_t rate_i,
    output logic       event_o
);

    localparam int unsigned NUM_RATES = 4;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [CNT_W-1:0] mask_tab [NUM_RATES];

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_mask
        localparam int unsigned EXP_G = rate_exp(BASE_EXP, EXP_STEP, g);
        assign mask_tab[g] = {CNT_W{1'b1}} >> (CNT_W - EXP_G);
    end

    logic [CNT_W-1:0] sel_mask;
    assign sel_mask = mask_tab[rate_i];
    assign event_o  = tick_i && ((st_q.cnt & sel_mask) == sel_mask);

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: without a tick or restart the count holds
    a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !restart_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/swd_wdog.sv
module swd_wdog #(
    parameter int unsigned LIMIT_EVENTS = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    input  logic kick_i,
    input  logic event_i,
    output logic fire_o,
    output logic armed_o
);

    localparam int unsigned CW   = $clog2(LIMIT_EVENTS + 1);
    localparam int unsigned LAST = LIMIT_EVENTS - 1;

    typedef struct packed {
        logic          en;
        logic [CW-1:0] cnt;
    } wd_state_t;

    wd_state_t st_d, st_q;

    assign fire_o  = st_q.en && event_i && !kick_i && (st_q.cnt == CW'(LAST));
    assign armed_o = st_q.en;

    always_comb begin
        st_d    = st_q;
        st_d.en = st_q.en | arm_i;
        if (kick_i || fire_o) begin
            st_d.cnt = '0;
        end else if (st_q.en && event_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: armed state is sticky until hard reset
    a_r9_sticky_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.en |=> st_q.en);

    // R6: count never reaches the limit
    a_r6_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CW'(LAST));

    // R5: an unarmed watchdog never counts
    a_r5_idle_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.en |-> st_q.cnt == '0);

endmodule

// File: rtl/sleep_watch_top.sv
module sleep_watch_top
    import swd_pkg::*;
#(
    parameter int unsigned BASE_EXP     = 6,
    parameter int unsigned EXP_STEP     = 3,
    parameter int unsigned LIMIT_EVENTS = 3
) (
    input  logic       clk_i,
    input  logic       por_n_i,
    input  logic       xrst_n_i,
    input  logic       tick_i,
    input  logic [1:0] rate_sel_i,
    input  logic       wd_arm_i,
    input  logic       wd_kick_i,
    input  logic       irq_en_i,
    output logic       sleep_irq_o,
    output logic       wd_reset_o
);

    localparam int unsigned CNT_W = BASE_EXP + 3 * EXP_STEP;

    logic     rst_n;
    logic     sleep_evt;
    logic     wd_fire;
    logic     wd_armed;
    swd_out_t out_d, out_q;

    assign rst_n = por_n_i & xrst_n_i;

    swd_divider #(
        .BASE_EXP (BASE_EXP),
        .EXP_STEP (EXP_STEP),
        .CNT_W    (CNT_W)
    ) i_divider (
        .clk_i     (clk_i),
        .rst_ni    (rst_n),
        .tick_i    (tick_i),
        .restart_i (wd_fire),
        .rate_i    (rate_code_t'(rate_sel_i)),
        .event_o   (sleep_evt)
    );

    swd_wdog #(
        .LIMIT_EVENTS (LIMIT_EVENTS)
    ) i_wdog (
        .clk_i   (clk_i),
        .rst_ni  (rst_n),
        .arm_i   (wd_arm_i),
        .kick_i  (wd_kick_i),
        .event_i (sleep_evt),
        .fire_o  (wd_fire),
        .armed_o (wd_armed)
    );

    always_comb begin
        out_d     = '0;
        out_d.irq = sleep_evt & irq_en_i;
        out_d.wdr = wd_fire;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sleep_irq_o = out_q.irq;
    assign wd_reset_o  = out_q.wdr;

    // R4: an interrupt pulse needs the mask open in the cycle before
    a_r4_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_n)
        sleep_irq_o |-> $past(irq_en_i));

    // R6: reset pulse is a single cycle
    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
        wd_reset_o |=> !wd_reset_o);

    // R7: a clear strobe suppresses the reset in its cycle
    a_r7_kick_blocks: assert property (@(posedge clk_i) disable iff (!rst_n)
        wd_kick_i |=> !wd_reset_o);

    // R8: the watchdog is still armed while its reset pulse is out
    a_r8_armed_after_fire: assert property (@(posedge clk_i) disable iff (!rst_n)
        wd_reset_o |-> wd_armed);

endmodule

// File: tb/test_sleep_watch_top.sv
module test_sleep_watch_top;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 2;
    localparam int STEP       = 1;
    localparam int CNTW       = BASE + 3 * STEP;
    localparam int MAX_CYC    = 200000;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       xrst_n = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] rate = 2'd0;
    logic       arm = 1'b0;
    logic       kick = 1'b0;
    logic       irq_en = 1'b1;
    logic       irq_o;
    logic       wdr_o;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    int wdr_seen = 0;
    int cycles = 0;
    string tag = "R10";

    // reference model state
    int  m_cnt = 0;
    int  m_wc = 0;
    bit  m_en = 0;
    bit  exp_irq = 0;
    bit  exp_wdr = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sleep_watch_top #(
        .BASE_EXP     (BASE),
        .EXP_STEP     (STEP),
        .LIMIT_EVENTS (3)
    ) i_sleep_watch_top (
        .clk_i       (clk),
        .por_n_i     (por_n),
        .xrst_n_i    (xrst_n),
        .tick_i      (tick),
        .rate_sel_i  (rate),
        .wd_arm_i    (arm),
        .wd_kick_i   (kick),
        .irq_en_i    (irq_en),
        .sleep_irq_o (irq_o),
        .wd_reset_o  (wdr_o)
    );

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    // behavioural reference, evaluated from the inputs only
    always @(posedge clk) begin
        int per;
        bit ev;
        bit fire;
        if (!(por_n && xrst_n)) begin
            m_cnt = 0; m_wc = 0; m_en = 0; exp_irq = 0; exp_wdr = 0;
        end else begin
            per  = 1 << (BASE + STEP * int'(rate));
            ev   = tick && ((m_cnt % per) == per - 1);
            fire = m_en && ev && !kick && (m_wc == 2);
            exp_irq = ev && irq_en;
            exp_wdr = fire;
            if (fire) m_cnt = 0;
            else if (tick) m_cnt = (m_cnt + 1) % (1 << CNTW);
            if (kick || fire) m_wc = 0;
            else if (m_en && ev) m_wc = m_wc + 1;
            if (arm) m_en = 1;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        check({tag, " irq"}, int'(irq_o), int'(exp_irq));
        check({tag, " wdr"}, int'(wdr_o), int'(exp_wdr));
        if (irq_o) irq_seen++;
        if (wdr_o) wdr_seen++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYC) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input bit t, input bit a, input bit k);
        @(negedge clk);
        #1;
        tick = t; arm = a; kick = k;
    endtask

    task automatic run(input int n, input int every);
        for (int i = 0; i < n; i++) step((i % every) == 0, 1'b0, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic hard_reset(input bit use_por);
        @(negedge clk);
        #1;
        tick = 0; arm = 0; kick = 0;
        if (use_por) por_n = 0; else xrst_n = 0;
        @(negedge clk);
        #1;
        por_n = 1; xrst_n = 1;
        irq_seen = 0; wdr_seen = 0;
    endtask

    task automatic clear_seen();
        @(negedge clk);
        #2;
        irq_seen = 0; wdr_seen = 0;
    endtask

    initial begin
        // R10: outputs quiet during and after reset
        tag = "R10";
        repeat (3) @(negedge clk);
        check("R10 irq in reset", int'(irq_o), 0);
        check("R10 wdr in reset", int'(wdr_o), 0);
        hard_reset(1'b1);

        // R1: two events per 2*2^e ticks for each rate code
        tag = "R1";
        for (int c = 0; c < 4; c++) begin
            rate = 2'(c);
            hard_reset(1'b0);
            run(2 * (1 << (BASE + STEP * c)), 1);
            idle(2);
            check($sformatf("R1 rate %0d pulses", c), irq_seen, 2);
        end

        // R2: ticks every third cycle
        tag = "R2";
        rate = 2'd0;
        hard_reset(1'b0);
        run(48, 3);
        idle(2);
        check("R2 sparse tick pulses", irq_seen, 4);

        // R4: masked interrupts
        tag = "R4";
        irq_en = 0;
        hard_reset(1'b0);
        run(16, 1);
        idle(2);
        check("R4 masked pulses", irq_seen, 0);
        irq_en = 1;

        // R3: rate change on a running count
        tag = "R3";
        rate = 2'd3;
        hard_reset(1'b0);
        run(5, 1);
        rate = 2'd0;
        clear_seen();
        run(3, 1);
        idle(2);
        check("R3 after switch pulses", irq_seen, 1);

        // R5: unarmed watchdog stays quiet
        tag = "R5";
        hard_reset(1'b1);
        run(64, 1);
        idle(2);
        check("R5 unarmed resets", wdr_seen, 0);

        // R6 and R8: armed, no clears
        tag = "R6";
        hard_reset(1'b0);
        step(1'b1, 1'b1, 1'b0);
        run(11, 1);
        idle(2);
        check("R6 first reset", wdr_seen, 1);
        tag = "R8";
        run(12, 1);
        idle(2);
        check("R8 second reset", wdr_seen, 2);

        // R7: clears every 8 ticks, some on event ticks
        tag = "R7";
        clear_seen();
        for (int i = 1; i <= 96; i++) step(1'b1, 1'b0, (i % 8) == 0);
        idle(2);
        check("R7 cleared resets", wdr_seen, 0);

        // R7: clear in the same cycle as the would-be third event
        hard_reset(1'b0);
        step(1'b1, 1'b1, 1'b0);
        run(10, 1);
        step(1'b1, 1'b0, 1'b1);
        idle(2);
        check("R7 coincident clear", wdr_seen, 0);

        // R9: clears never disarm; external reset does
        tag = "R9";
        clear_seen();
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1);
        run(12, 1);
        idle(2);
        check("R9 still armed", wdr_seen, 1);
        hard_reset(1'b0);
        run(64, 1);
        idle(2);
        check("R9 disarmed by reset", wdr_seen, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule